// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two operands held in the IEEE-754 single-precision format. Each operand is split into sign, exponent and significand. The exponents are subtracted to find which operand has the larger magnitude and how far the smaller one must be shifted. When the exponents are equal, a 24-bit significand comparison decides which operand is larger. The smaller significand is aligned into a 27-bit field. That field is the hidden one, 23 fraction bits, then guard, round and sticky bits. The two significands are then added, or subtracted when the effective signs differ. The result is normalised with a leading-zero count and a barrel shift, rounded to nearest with ties to even, and packed.

The unit accepts one operation per clock. A select input turns addition into subtraction by inverting the sign of the second operand. Each operation carries a valid flag with it. The flag and the result come out ten clock edges after the operation is taken. Subnormal operands are treated as zero. A result too small for a normal number becomes a signed zero, and a result too large becomes a signed infinity. Not-a-number and infinity inputs follow a short fixed rule set.

Top module: `fp_add_pipe`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge produces `out_valid` high, with its result on `out_res`, after the 10th rising edge counting the one that took it. Operations on consecutive cycles come out on consecutive cycles, and a cycle with `in_valid` low gives a cycle with `out_valid` low.
- R2: With `in_sub` = 0 and two finite normal operands, `out_res` is the sum rounded to nearest with ties to even.
- R3: With `in_sub` = 1, `out_res` is `in_a` minus `in_b`, computed as the sum of `in_a` and `in_b` with bit 31 of `in_b` inverted.
- R4: An effective subtraction whose exact result is zero returns +0 (0x00000000). Adding two zeros of the same sign returns a zero of that sign.
- R5: A result exactly halfway between two representable values rounds to the one whose least significant fraction bit is 0.
- R6: An operand with exponent field 0 is treated as zero, whatever its fraction bits.
- R7: A rounded result whose biased exponent reaches 255 or more returns infinity with the result sign: 0x7F800000 or 0xFF800000.
- R8: A rounded result whose biased exponent is 0 or below returns zero with the result sign. `out_res` never carries exponent field 0 with a non-zero fraction.
- R9: If either operand is a NaN (exponent 255, non-zero fraction), or both are infinities whose effective signs differ, the result is 0x7FC00000. Otherwise a single infinity operand, or two infinities with the same effective sign, returns that infinity with its effective sign.
- R10: While `rst_n` is low, and until the first accepted operation has passed through, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand, single precision |
| in_sub | input | 1 | 1 = subtract `in_b` from `in_a`, 0 = add |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Rounded single-precision result |

## Verification
The hardest case to reach from the ports is an effective subtraction of operands with nearly equal exponents. There the leading bits cancel, the normaliser shifts left by many places, and the rounding or the underflow flush depends on the guard and sticky bits left after alignment. Uniformly random operands almost never produce this. So the stimulus draws the second exponent within a few steps of the first, and sometimes copies the first exponent and most of its fraction. Directed vectors add exact ties, exact cancellations near the smallest normal exponent, overflow at the largest finite value, and the special operand codes. Idle gaps are mixed into the stream.

// File: rtl/fpa_pkg.sv
// fpa_pkg: types and helpers shared by the stages of the float adder.
// Assumes IEEE-754 single-precision layout: sign [31], exponent [30:23],
// fraction [22:0].
package fpa_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;      // significand with hidden one
    localparam int EXT_W  = SIG_W + 3;       // plus guard, round, sticky
    localparam int LZ_W   = $clog2(EXT_W + 1);
    localparam int XE_W   = EXP_W + 2;       // signed exponent headroom

    localparam logic [31:0] QNAN = 32'h7FC0_0000;

    // after compare: larger and smaller significand, shift distance
    typedef struct packed {
        logic              spec;
        logic [31:0]       spec_val;
        logic              sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  m_big;
        logic [SIG_W-1:0]  m_sml;
        logic [EXP_W-1:0]  shamt;
    } cmp_t;

    // after alignment: both operands as extended significands
    typedef struct packed {
        logic              spec;
        logic [31:0]       spec_val;
        logic              sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp;
        logic [EXT_W-1:0]  x_big;
        logic [EXT_W-1:0]  x_sml;
    } aln_t;

    // after add: raw sum with carry bit
    typedef struct packed {
        logic              spec;
        logic [31:0]       spec_val;
        logic              sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp;
        logic [EXT_W:0]    sum;
    } sum_t;

    // after normalise: leading one at the top of nrm
    typedef struct packed {
        logic              spec;
        logic [31:0]       spec_val;
        logic              sign;
        logic              zero;
        logic [XE_W-1:0]   xexp;
        logic [EXT_W-1:0]  nrm;
    } nrm_t;

    // number of zero bits above the leading one (EXT_W when all zero)
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] cnt;
        logic            hit;
        cnt = '0;
        hit = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      cnt = cnt + 1'b1;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/fpa_align.sv
// fpa_align: unpack, special-case detection, magnitude compare and
// alignment (two register stages).
// Assumes subnormal operands count as zero; the subtract select
// inverts the sign of operand B.
module fpa_align
    import fpa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic        in_sub,
    output logic        out_valid,
    output aln_t        out_st
);
    localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] SH_CAP  = EXP_W'(EXT_W);

    logic             sa, sb;
    logic [EXP_W-1:0] ea, eb;
    logic [SIG_W-1:0] ma, mb;
    logic             nan_a, nan_b, inf_a, inf_b, a_big;
    cmp_t             cmp_d, cmp_q;
    logic             cmp_v;

    // unpack, classify and choose the larger operand
    always_comb begin
        sa    = in_a[31];
        sb    = in_b[31] ^ in_sub;
        ea    = in_a[30:23];
        eb    = in_b[30:23];
        ma    = (ea == '0) ? '0 : {1'b1, in_a[22:0]};
        mb    = (eb == '0) ? '0 : {1'b1, in_b[22:0]};
        nan_a = (ea == EXP_MAX) && (in_a[22:0] != '0);
        nan_b = (eb == EXP_MAX) && (in_b[22:0] != '0);
        inf_a = (ea == EXP_MAX) && (in_a[22:0] == '0);
        inf_b = (eb == EXP_MAX) && (in_b[22:0] == '0);
        a_big = (ea > eb) || ((ea == eb) && (ma >= mb));

        cmp_d.spec     = nan_a | nan_b | inf_a | inf_b;
        cmp_d.spec_val = (nan_a | nan_b | (inf_a & inf_b & (sa ^ sb))) ? QNAN :
                         inf_a ? {sa, EXP_MAX, 23'd0} : {sb, EXP_MAX, 23'd0};
        cmp_d.sign     = a_big ? sa : sb;
        cmp_d.eff_sub  = sa ^ sb;
        cmp_d.exp      = a_big ? ea : eb;
        cmp_d.m_big    = a_big ? ma : mb;
        cmp_d.m_sml    = a_big ? mb : ma;
        cmp_d.shamt    = a_big ? (ea - eb) : (eb - ea);
    end

    // stage 1 register
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_v <= 1'b0;
        else        cmp_v <= in_valid;
        cmp_q <= cmp_d;
    end

    logic [LZ_W-1:0]    sh;
    logic [2*EXT_W-1:0] wide;
    aln_t               aln_d;

    // shift the smaller significand right, folding lost bits into sticky
    always_comb begin
        sh   = (cmp_q.shamt > SH_CAP) ? SH_CAP[LZ_W-1:0] : cmp_q.shamt[LZ_W-1:0];
        wide = {cmp_q.m_sml, 3'b000, {EXT_W{1'b0}}} >> sh;
        aln_d.spec     = cmp_q.spec;
        aln_d.spec_val = cmp_q.spec_val;
        aln_d.sign     = cmp_q.sign;
        aln_d.eff_sub  = cmp_q.eff_sub;
        aln_d.exp      = cmp_q.exp;
        aln_d.x_big    = {cmp_q.m_big, 3'b000};
        aln_d.x_sml    = {wide[2*EXT_W-1:EXT_W+1], wide[EXT_W] | (|wide[EXT_W-1:0])};
    end

    // stage 2 register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= cmp_v;
        out_st <= aln_d;
    end
endmodule

// File: rtl/fpa_addnorm.sv
// fpa_addnorm: extended-significand add/subtract, then normalisation by
// leading-zero count and barrel shift (two register stages).
// Assumes x_big >= x_sml, so a subtraction never goes negative.
module fpa_addnorm
    import fpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  aln_t in_st,
    output logic out_valid,
    output nrm_t out_st
);
    sum_t sum_q;
    logic sum_v;

    // stage 3: add or subtract the aligned significands
    always_ff @(posedge clk) begin
        if (!rst_n) sum_v <= 1'b0;
        else        sum_v <= in_valid;
        sum_q.spec     <= in_st.spec;
        sum_q.spec_val <= in_st.spec_val;
        sum_q.sign     <= in_st.sign;
        sum_q.eff_sub  <= in_st.eff_sub;
        sum_q.exp      <= in_st.exp;
        sum_q.sum      <= in_st.eff_sub ? ({1'b0, in_st.x_big} - {1'b0, in_st.x_sml})
                                        : ({1'b0, in_st.x_big} + {1'b0, in_st.x_sml});
    end

    logic [LZ_W-1:0] lz;
    logic [XE_W-1:0] xe;
    nrm_t            nrm_d;

    // bring the leading one to the top bit and correct the exponent
    always_comb begin
        lz = lead_zeros(sum_q.sum[EXT_W-1:0]);
        xe = {2'b00, sum_q.exp};
        nrm_d.spec     = sum_q.spec;
        nrm_d.spec_val = sum_q.spec_val;
        nrm_d.zero     = (sum_q.sum == '0);
        nrm_d.sign     = (nrm_d.zero && sum_q.eff_sub) ? 1'b0 : sum_q.sign;
        if (sum_q.sum[EXT_W]) begin
            nrm_d.nrm  = {sum_q.sum[EXT_W:2], sum_q.sum[1] | sum_q.sum[0]};
            nrm_d.xexp = xe + 1'b1;
        end else begin
            nrm_d.nrm  = sum_q.sum[EXT_W-1:0] << lz;
            nrm_d.xexp = xe - {{(XE_W-LZ_W){1'b0}}, lz};
        end
    end

    // stage 4 register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= sum_v;
        out_st <= nrm_d;
    end
endmodule

// File: rtl/fpa_round.sv
// fpa_round: round to nearest even, carry renormalise, range check and
// packing (one register stage).
// Assumes nrm has its leading one at the top unless zero is set.
module fpa_round
    import fpa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  nrm_t        in_st,
    output logic        out_valid,
    output logic [31:0] out_res
);
    logic             up;
    logic [SIG_W:0]   rsum;
    logic [SIG_W-1:0] mant;
    logic [XE_W-1:0]  fexp;
    logic [31:0]      res_d;

    // increment on guard when round/sticky/lsb allow, then pick the result
    always_comb begin
        up   = in_st.nrm[2] & (in_st.nrm[1] | in_st.nrm[0] | in_st.nrm[3]);
        rsum = {1'b0, in_st.nrm[EXT_W-1:3]} + {{SIG_W{1'b0}}, up};
        if (rsum[SIG_W]) begin
            mant = rsum[SIG_W:1];
            fexp = in_st.xexp + 1'b1;
        end else begin
            mant = rsum[SIG_W-1:0];
            fexp = in_st.xexp;
        end
        if (in_st.spec)
            res_d = in_st.spec_val;
        else if (in_st.zero)
            res_d = {in_st.sign, 31'd0};
        else if ($signed(fexp) >= $signed(XE_W'(255)))
            res_d = {in_st.sign, 8'hFF, 23'd0};
        else if ($signed(fexp) <= $signed(XE_W'(0)))
            res_d = {in_st.sign, 31'd0};
        else
            res_d = {in_st.sign, fexp[EXP_W-1:0], mant[FRAC_W-1:0]};
    end

    // stage 5 register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
        out_res <= res_d;
    end
endmodule

// File: rtl/fpa_delay.sv
// fpa_delay: plain register chain that fills the pipeline to its fixed depth.
// Assumes DEPTH >= 0; at 0 the data passes straight through.
module fpa_delay #(
    parameter int W     = 32,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_chain
            logic         vq [DEPTH];
            logic [W-1:0] dq [DEPTH];
            // shift valid and data one place per clock
            always_ff @(posedge clk) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!rst_n)      vq[i] <= 1'b0;
                    else if (i == 0) vq[i] <= in_valid;
                    else             vq[i] <= vq[i-1];
                    dq[i] <= (i == 0) ? in_data : dq[i-1];
                end
            end
            assign out_valid = vq[DEPTH-1];
            assign out_data  = dq[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/fp_add_pipe.sv
// fp_add_pipe: single-precision add/subtract pipeline of fixed depth.
// Assumes LATENCY >= 5; the arithmetic uses five register stages and the
// rest is padding.
module fp_add_pipe
    import fpa_pkg::*;
#(
    parameter int LATENCY = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic        in_sub,
    output logic        out_valid,
    output logic [31:0] out_res
);
    localparam int CORE = 5;
    localparam int PAD  = LATENCY - CORE;

    logic        aln_v, nrm_v, rnd_v;
    aln_t        aln_st;
    nrm_t        nrm_st;
    logic [31:0] rnd_res;

    fpa_align u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
        .in_b(in_b), .in_sub(in_sub), .out_valid(aln_v), .out_st(aln_st)
    );

    fpa_addnorm u_addnorm (
        .clk(clk), .rst_n(rst_n), .in_valid(aln_v), .in_st(aln_st),
        .out_valid(nrm_v), .out_st(nrm_st)
    );

    fpa_round u_round (
        .clk(clk), .rst_n(rst_n), .in_valid(nrm_v), .in_st(nrm_st),
        .out_valid(rnd_v), .out_res(rnd_res)
    );

    fpa_delay #(.W(32), .DEPTH(PAD)) u_pad (
        .clk(clk), .rst_n(rst_n), .in_valid(rnd_v), .in_data(rnd_res),
        .out_valid(out_valid), .out_data(out_res)
    );
endmodule

// File: rtl/fp_add_pipe_chk.sv
// fp_add_pipe_chk: port-level properties of fp_add_pipe, attached by bind.
// Assumes the same LATENCY as the design; it keeps its own history registers.
module fp_add_pipe_chk #(
    parameter int LATENCY = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic        out_valid,
    input logic [31:0] out_res
);
    logic [LATENCY-1:0] vhist, nhist;
    logic               nan_in;

    // an input NaN on either operand
    always_comb begin
        nan_in = ((in_a[30:23] == 8'hFF) && (in_a[22:0] != '0)) ||
                 ((in_b[30:23] == 8'hFF) && (in_b[22:0] != '0));
    end

    // remember which accepted inputs were valid and which carried a NaN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vhist <= '0;
            nhist <= '0;
        end else begin
            vhist <= {vhist[LATENCY-2:0], in_valid};
            nhist <= {nhist[LATENCY-2:0], in_valid & nan_in};
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[LATENCY-1]); // R1

    AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !((out_res[30:23] == 8'h00) && (out_res[22:0] != '0))); // R8

    AST_TOP_EXP_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res[30:23] == 8'hFF) |-> ((out_res[22:0] == '0) || (out_res == 32'h7FC0_0000))); // R7

    AST_NAN_PROPAGATE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nhist[LATENCY-1]) |-> (out_res == 32'h7FC0_0000)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R10
endmodule

bind fp_add_pipe fp_add_pipe_chk #(.LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
    .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
);

// File: tb/fp_add_pipe_tb.sv
// fp_add_pipe_tb: drives directed and random operations and compares each
// output cycle with a behavioural exact-arithmetic model.
module fp_add_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 10;
    localparam int HSZ        = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_res;
    int          cur_tag = 0;

    int tests = 0, fails = 0, pc = 0;
    logic        hv [HSZ];
    logic [31:0] hr [HSZ];
    int          ht [HSZ];
    logic [31:0] rng = 32'h1234_5678;

    fp_add_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
        .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid), .out_res(out_res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tname(input int t);
        case (t)
            2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
            6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
            default: return "R1";
        endcase
    endfunction

    // exact model: wide integer alignment, then round to 24 bits
    function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
        int ea, eb, eg, es, d, p, e, sh;
        logic sa, sbx, sg, eff;
        longint unsigned ma, mb, mg, ms, vg, vs, r, q, rem, half;
        sa = a[31]; sbx = b[31] ^ sub;
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 32'h7FC00000;
        if (ea == 255 && eb == 255) return (sa != sbx) ? 32'h7FC00000 : {sa, 8'hFF, 23'd0};
        if (ea == 255) return {sa, 8'hFF, 23'd0};
        if (eb == 255) return {sbx, 8'hFF, 23'd0};
        ma = (ea == 0) ? 64'd0 : (64'h800000 | longint'(a[22:0]));
        mb = (eb == 0) ? 64'd0 : (64'h800000 | longint'(b[22:0]));
        if (ma == 0 && mb == 0) return {sa & sbx, 31'd0};
        eff = sa ^ sbx;
        if (ea > eb || (ea == eb && ma >= mb)) begin
            eg = ea; es = eb; mg = ma; ms = mb; sg = sa;
        end else begin
            eg = eb; es = ea; mg = mb; ms = ma; sg = sbx;
        end
        d  = eg - es;
        vg = mg << 30;
        if (d > 30) vs = (ms != 0) ? 64'd1 : 64'd0;
        else        vs = (ms << 30) >> d;
        r = eff ? (vg - vs) : (vg + vs);
        if (r == 0) return 32'h0;
        p = 0;
        for (int i = 0; i < 64; i++) if (r[i]) p = i;
        e = eg + p - 53;
        if (p > 23) begin
            sh   = p - 23;
            q    = r >> sh;
            rem  = r & ((64'd1 << sh) - 1);
            half = 64'd1 << (sh - 1);
            if (rem > half || (rem == half && q[0])) q = q + 1;
            if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
        end else begin
            q = r << (23 - p);
        end
        if (e >= 255) return {sg, 8'hFF, 23'd0};
        if (e <= 0)   return {sg, 31'd0};
        return {sg, e[7:0], q[22:0]};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // record what each sampling edge should produce LAT edges later
    always @(posedge clk) begin
        pc = pc + 1;
        hv[pc % HSZ] = rst_n && in_valid;
        hr[pc % HSZ] = ref_add(in_a, in_b, in_sub);
        ht[pc % HSZ] = cur_tag;
    end

    // compare the outputs once per cycle, away from the edge
    always @(negedge clk) begin
        logic        ev;
        logic [31:0] er;
        int          et;
        if (rst_n && pc > LAT) begin
            ev = hv[(pc - (LAT - 1)) % HSZ];
            er = hr[(pc - (LAT - 1)) % HSZ];
            et = ht[(pc - (LAT - 1)) % HSZ];
            if (ev || out_valid) begin
                tests = tests + 1;
                if (out_valid !== ev) begin
                    fails = fails + 1;
                    $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, ev);
                end else if (out_res !== er) begin
                    fails = fails + 1;
                    $display("FAIL %s out_res actual %08h expected %08h", tname(et), out_res, er);
                end
            end
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s, input int tag);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_sub = s; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
            if (cyc > 100000) begin
                fails = fails + 1;
                tests = tests + 1;
                $display("FAIL R1 watchdog actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] a, b;
        logic [7:0]  eb8;
        int          ebi;
        repeat (4) @(negedge clk);
        // R10: nothing valid while held in reset
        tests = tests + 1;
        if (out_valid !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R10 out_valid actual %0b expected 0", out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(12);
        tests = tests + 1;
        if (out_valid !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R10 out_valid after reset actual %0b expected 0", out_valid);
        end

        // R2 plain sums
        send(32'h3F800000, 32'h3F800000, 1'b0, 2);
        send(32'h40490FDB, 32'h3F000000, 1'b0, 2);
        // R3 subtraction select
        send(32'h3FC00000, 32'h3F000000, 1'b1, 3);
        send(32'h3F000000, 32'h3FC00000, 1'b1, 3);
        // R4 exact cancellation and signed zeros
        send(32'h3F800000, 32'h3F800000, 1'b1, 4);
        send(32'hBF800000, 32'h3F800000, 1'b0, 4);
        send(32'h80000000, 32'h80000000, 1'b0, 4);
        send(32'h00000000, 32'h00000000, 1'b1, 4);
        // R5 exact ties
        send(32'h3F800000, 32'h33800000, 1'b0, 5);
        send(32'h3F800001, 32'h33800000, 1'b0, 5);
        send(32'h3F800000, 32'h33000000, 1'b1, 5);
        // R6 subnormal operands count as zero
        send(32'h00000001, 32'h3F800000, 1'b0, 6);
        send(32'h007FFFFF, 32'h00400000, 1'b0, 6);
        // R7 overflow
        send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 7);
        send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 7);
        // R8 underflow after cancellation
        send(32'h00800001, 32'h00800000, 1'b1, 8);
        send(32'h80800001, 32'h80800000, 1'b1, 8);
        // R9 special operands
        send(32'h7FC00001, 32'h3F800000, 1'b0, 9);
        send(32'h7F800000, 32'h7F800000, 1'b1, 9);
        send(32'h7F800000, 32'h3F800000, 1'b0, 9);
        send(32'h3F800000, 32'h7F800000, 1'b1, 9);
        idle(3);

        // R1 R2 R3 random stream with near-equal exponents and gaps
        for (int k = 0; k < 3000; k++) begin
            rng = next_rand(rng);
            a   = rng;
            if (a[30:23] == 8'hFF) a[30:23] = 8'hFE;
            if (a[30:23] == 8'h00) a[30:23] = 8'h01;
            rng = next_rand(rng);
            b   = rng;
            if (rng[1:0] != 2'b00) begin
                ebi = int'(a[30:23]) + int'(rng[6:4]) - 3;
                if (ebi < 1)   ebi = 1;
                if (ebi > 254) ebi = 254;
                eb8 = ebi[7:0];
                b[30:23] = eb8;
                if (rng[8]) b[22:8] = a[22:8];
            end
            if (rng[12:9] == 4'h0) idle(1 + int'(rng[14:13]));
            send(a, b, rng[15], rng[15] ? 3 : 2);
        end
        idle(LAT + 4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule